// File: doc/BRIEF.md
# Instruction-Fence Flush Sequencer

This block orders the cache maintenance that an instruction fence needs in a core whose data cache writes back. A one-cycle commit pulse starts a fence. The block then asks the instruction cache and the data cache to flush, and it records each flush's completion separately. It keeps the fetch frontend frozen until both caches have reported. Fetch never resumes on the instruction-cache flush alone, because dirty code lines may still be leaving the data cache.

The frontend is frozen in two ways. The block masks the fetch request that goes to the instruction cache, and it masks the ready signal that lets the next-PC logic advance. In the last frozen cycle the block presents the address that follows the fence, so that fetch restarts there.

Top module: `ifence_flush_seq`

## Requirements
- R1: After reset, `haltFrontend`, `icFlushReq`, `dcFlushReq` and `resumeValid` are all low.
- R2: A `fenceCommit` pulse while idle makes `haltFrontend`, `icFlushReq` and `dcFlushReq` high from the next cycle onward.
- R3: Each flush request stays high until its own done input is seen, and is low from the cycle after that done.
- R4: `haltFrontend` stays high until both done inputs have been seen, whichever cache finishes first and including when both finish in the same cycle. It is low from the second cycle after the later done.
- R5: `fetchReqOut` equals `fetchReqIn` while `haltFrontend` is low, and it is low while `haltFrontend` is high.
- R6: `fetchReadyOut` equals `fetchReadyIn` while `haltFrontend` is low, and it is low while `haltFrontend` is high.
- R7: A `fenceCommit` that arrives while a fence is active is ignored. The flush timing and `resumePc` are unchanged.
- R8: `resumeValid` is high for exactly one cycle, the last cycle in which `haltFrontend` is high. In that cycle `resumePc` equals the fence PC plus `INSTR_BYTES`.
- R9: Done pulses that arrive while no fence is active are not remembered. The next fence still waits for fresh done inputs from both caches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fenceCommit | input | 1 | One-cycle pulse: an instruction fence commits |
| fencePc | input | PC_W | PC of the committing fence, sampled with `fenceCommit` |
| icFlushReq | output | 1 | Flush request to the instruction cache |
| icFlushDone | input | 1 | Instruction-cache flush completed |
| dcFlushReq | output | 1 | Flush/write-back request to the data cache |
| dcFlushDone | input | 1 | Data-cache flush completed |
| haltFrontend | output | 1 | Frontend frozen while a fence is in progress |
| fetchReqIn | input | 1 | Fetch request from the frontend |
| fetchReqOut | output | 1 | Gated fetch request to the instruction cache |
| fetchReadyIn | input | 1 | Fetch-ready that lets the next PC advance |
| fetchReadyOut | output | 1 | Gated fetch-ready to the next-PC logic |
| resumeValid | output | 1 | Last frozen cycle; fetch restarts at `resumePc` |
| resumePc | output | PC_W | Address that follows the fence |

## Verification
The assertions assume that each cache raises its done input only while its own request is high or in the cycle the request is seen. They also assume that a commit pulse lasts a single cycle. The stimulus follows both assumptions. It raises each done exactly once per fence, at a chosen delay after the halt rises. Its only extra commit comes while the fence is already active or while the block is idle, and the only stray dones come while the block is idle. A sweep over every pair of done delays from 0 to 5 covers the case where the instruction cache finishes first, the case where the data cache finishes first, and the case where both finish in the same cycle.

// File: rtl/ifence_pkg.sv
package ifence_pkg;
  typedef struct packed {
    logic startFence;
    logic clearFlags;
  } seqStrobes_t;
endpackage

// File: rtl/ifence_ctrl.sv
module ifence_ctrl
  import ifence_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fenceCommit,
  input  logic        bothDone,
  output logic        active,
  output seqStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_ACTIVE} seqState_t;
  seqState_t state;

  always_comb begin
    strobes.startFence = (state == ST_IDLE) && fenceCommit;
    strobes.clearFlags = (state == ST_ACTIVE) && bothDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   state <= ST_IDLE;
    else if (strobes.startFence) state <= ST_ACTIVE;
    else if (strobes.clearFlags) state <= ST_IDLE;
  end

  assign active = (state == ST_ACTIVE);
endmodule

// File: rtl/ifence_dpath.sv
module ifence_dpath
  import ifence_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            active,
  input  seqStrobes_t     strobes,
  input  logic            icFlushDone,
  input  logic            dcFlushDone,
  input  logic [PC_W-1:0] fencePc,
  output logic            icFlag,
  output logic            dcFlag,
  output logic            bothDone,
  output logic [PC_W-1:0] resumePc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      icFlag <= 1'b0;
      dcFlag <= 1'b0;
    end else if (strobes.clearFlags) begin
      icFlag <= 1'b0;
      dcFlag <= 1'b0;
    end else if (active) begin
      icFlag <= icFlag | icFlushDone;
      dcFlag <= dcFlag | dcFlushDone;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   resumePc <= '0;
    else if (strobes.startFence) resumePc <= fencePc + STEP;
  end

  assign bothDone = icFlag & dcFlag;
endmodule

// File: rtl/ifence_flush_seq.sv
module ifence_flush_seq
  import ifence_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fenceCommit,
  input  logic [PC_W-1:0] fencePc,
  output logic            icFlushReq,
  input  logic            icFlushDone,
  output logic            dcFlushReq,
  input  logic            dcFlushDone,
  output logic            haltFrontend,
  input  logic            fetchReqIn,
  output logic            fetchReqOut,
  input  logic            fetchReadyIn,
  output logic            fetchReadyOut,
  output logic            resumeValid,
  output logic [PC_W-1:0] resumePc
);
  seqStrobes_t strobes;
  logic active, icFlag, dcFlag, bothDone;

  ifence_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .fenceCommit(fenceCommit),
    .bothDone(bothDone), .active(active), .strobes(strobes)
  );

  ifence_dpath #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) i_dpath (
    .clk(clk), .rstN(rstN), .active(active), .strobes(strobes),
    .icFlushDone(icFlushDone), .dcFlushDone(dcFlushDone),
    .fencePc(fencePc), .icFlag(icFlag), .dcFlag(dcFlag),
    .bothDone(bothDone), .resumePc(resumePc)
  );

  assign haltFrontend  = active;
  assign icFlushReq    = active & ~icFlag;
  assign dcFlushReq    = active & ~dcFlag;
  assign fetchReqOut   = fetchReqIn & ~active;
  assign fetchReadyOut = fetchReadyIn & ~active;
  assign resumeValid   = active & bothDone;
endmodule

// File: rtl/ifence_flush_seq_chk.sv
module ifence_flush_seq_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            fenceCommit,
  input logic            icFlushReq,
  input logic            icFlushDone,
  input logic            dcFlushReq,
  input logic            dcFlushDone,
  input logic            haltFrontend,
  input logic            fetchReqOut,
  input logic            fetchReadyOut,
  input logic            resumeValid,
  input logic [PC_W-1:0] resumePc
);
  AST_START_FENCE: assert property (@(posedge clk) disable iff (!rstN)
    (!haltFrontend && fenceCommit) |=> (haltFrontend && icFlushReq && dcFlushReq)); // R2
  AST_IC_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (icFlushReq && icFlushDone) |=> !icFlushReq); // R3
  AST_DC_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (dcFlushReq && dcFlushDone) |=> !dcFlushReq); // R3
  AST_REQ_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    (icFlushReq || dcFlushReq) |-> haltFrontend); // R4
  AST_RELEASE_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haltFrontend) |-> $past(resumeValid)); // R4
  AST_NO_FETCH_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    haltFrontend |-> !fetchReqOut); // R5
  AST_NO_READY_HALTED: assert property (@(posedge clk) disable iff (!rstN)
    haltFrontend |-> !fetchReadyOut); // R6
  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (haltFrontend && $past(haltFrontend)) |-> $stable(resumePc)); // R7
  AST_RESUME_LAST: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |=> !haltFrontend); // R8
endmodule

bind ifence_flush_seq ifence_flush_seq_chk #(.PC_W(PC_W)) i_chk (
  .clk(clk), .rstN(rstN), .fenceCommit(fenceCommit),
  .icFlushReq(icFlushReq), .icFlushDone(icFlushDone),
  .dcFlushReq(dcFlushReq), .dcFlushDone(dcFlushDone),
  .haltFrontend(haltFrontend), .fetchReqOut(fetchReqOut),
  .fetchReadyOut(fetchReadyOut), .resumeValid(resumeValid),
  .resumePc(resumePc)
);

// File: tb/test_ifence_flush_seq.sv
`timescale 1ns/1ps
module test_ifence_flush_seq;
  localparam int PC_W = 32;
  localparam int INSTR_BYTES = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic fenceCommit = 1'b0, icFlushDone = 1'b0, dcFlushDone = 1'b0;
  logic fetchReqIn = 1'b0, fetchReadyIn = 1'b0;
  logic [PC_W-1:0] fencePc = '0;
  logic icFlushReq, dcFlushReq, haltFrontend, fetchReqOut, fetchReadyOut, resumeValid;
  logic [PC_W-1:0] resumePc;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ifence_flush_seq #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) i_ifence_flush_seq (
    .clk(clk), .rstN(rstN), .fenceCommit(fenceCommit), .fencePc(fencePc),
    .icFlushReq(icFlushReq), .icFlushDone(icFlushDone),
    .dcFlushReq(dcFlushReq), .dcFlushDone(dcFlushDone),
    .haltFrontend(haltFrontend), .fetchReqIn(fetchReqIn), .fetchReqOut(fetchReqOut),
    .fetchReadyIn(fetchReadyIn), .fetchReadyOut(fetchReadyOut),
    .resumeValid(resumeValid), .resumePc(resumePc)
  );

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Runs one fence; dones arrive di / dd cycles after halt rises.
  // When extraCommit is set, a second commit with a different PC comes in cycle 1.
  task automatic runFence(input int di, input int dd, input logic [PC_W-1:0] pc,
                          input bit extraCommit);
    int m;
    logic expHalt;
    m = (di > dd) ? di : dd;
    @(negedge clk);
    fenceCommit = 1'b1; fencePc = pc;
    @(negedge clk);
    fenceCommit = 1'b0;
    for (int n = 0; n <= m + 3; n++) begin
      icFlushDone  = (n == di);
      dcFlushDone  = (n == dd);
      fenceCommit  = extraCommit && (n == 1);
      fencePc      = (n == 1) ? pc + 32'h100 : pc;
      fetchReqIn   = n[0];
      fetchReadyIn = ~n[0];
      expHalt = (n <= m + 1);
      #1;
      chk("R2/R4 halt", PC_W'(haltFrontend), PC_W'(expHalt));
      chk("R3 icReq", PC_W'(icFlushReq), PC_W'(n <= di));
      chk("R3 dcReq", PC_W'(dcFlushReq), PC_W'(n <= dd));
      chk("R5 fetchReq", PC_W'(fetchReqOut), PC_W'(fetchReqIn & ~expHalt));
      chk("R6 fetchReady", PC_W'(fetchReadyOut), PC_W'(fetchReadyIn & ~expHalt));
      chk("R8 resumeValid", PC_W'(resumeValid), PC_W'(n == m + 1));
      if (n == m + 1) chk("R7/R8 resumePc", resumePc, pc + PC_W'(INSTR_BYTES));
      if (n < m + 2) @(negedge clk);
      else begin
        fenceCommit = 1'b0;
        @(negedge clk);
      end
    end
    icFlushDone = 1'b0; dcFlushDone = 1'b0; fenceCommit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 halt", PC_W'(haltFrontend), 0);
    chk("R1 icReq", PC_W'(icFlushReq), 0);
    chk("R1 dcReq", PC_W'(dcFlushReq), 0);
    chk("R1 resumeValid", PC_W'(resumeValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 halt after release", PC_W'(haltFrontend), 0);
    fetchReqIn = 1'b1; fetchReadyIn = 1'b1;
    #1;
    chk("R5 idle pass", PC_W'(fetchReqOut), 1);
    chk("R6 idle pass", PC_W'(fetchReadyOut), 1);

    // Sweep: ic first, dc first, and both in the same cycle.
    for (int di = 0; di <= 5; di++)
      for (int dd = 0; dd <= 5; dd++)
        runFence(di, dd, PC_W'(32'h8000_0000 + di * 64 + dd * 8), ((di + dd) % 2) == 1);

    // R9: stray dones while idle must not be remembered.
    @(negedge clk);
    icFlushDone = 1'b1; dcFlushDone = 1'b1;
    @(negedge clk);
    icFlushDone = 1'b0; dcFlushDone = 1'b0;
    runFence(2, 4, 32'h0000_1000, 1'b0);
    summary();
  end
endmodule